// File: doc/BRIEF.md
# SAR Conversion Sequencer with Serial Result Output

This block is the digital timing and control core of a successive-approximation converter. On each conversion frame it first lets the analog front end calibrate and track. It then orders the track-and-hold to hold and walks a trial code down from the most significant bit, using a one-bit comparator decision for each bit. Each decided bit is sent out on a single serial data line in the same clock in which it is decided, most significant bit first. A separate enable output controls the tri-state driver of the data pin.

A frame is always twelve clocks long: two clocks for calibration and tracking, one clock for the sample, eight decision clocks, and one closing clock. No register selects the operating mode. The mode follows only from how the active-low start line is driven:

- **Single-shot:** start is high when the frame closes. The pin floats and the block waits.
- **Free-run:** start is held low. Frames follow back to back with the pin held low in between.
- **Synchronized:** start is released during the frame and lowered again later, either before the frame closes or after an idle gap.

The comparator is a plain digital input. It is high when the analog input is at or above the level that the current trial code selects.

Top module: `sar_serial_sequencer`

## Requirements
- R1: A frame lasts exactly 12 rising clock edges. Clock 1 is the first rising edge that finds `start_n` low while the block is idle, or the rising edge right after clock 12 when the next frame follows at once.
- R2: From clock 1 onward `sdata_oe` is high and `sdata` is low until the first decided bit appears.
- R3: `hold` rises at the falling edge of clock 3 and falls at the falling edge of clock 12. It is low while the block is idle.
- R4: At the falling edge of clock 3 `trial_code` becomes the most-significant-bit-only pattern (bit 7 set, all other bits clear). At the falling edge of clock 4+k (k = 0..7) bit 7-k keeps the value of `cmp_hi` (1 keeps the bit, 0 clears it), and bit 6-k is set when k < 7.
- R5: At the falling edge of clock 4+k, `sdata` shows the bit decided in that edge. Bit 7 appears first, at clock 4, and bit 0 appears at clock 11. Bit 0 is withdrawn at the rising edge of clock 12, so `sdata` is low during the high half of clock 12.
- R6: The result is straight binary. With a comparator that reports input ≥ trial, the final `trial_code` and the serial bits equal the input code, including 0x00 and 0xFF.
- R7: If `start_n` is high at the falling edge of clock 12, `sdata_oe` drops at that edge. The block then stays idle, with `sdata_oe`, `sdata` and `hold` low, until a rising edge finds `start_n` low.
- R8: If `start_n` is low at the falling edge of clock 12, `sdata_oe` stays high, `sdata` stays low, and the next frame begins at the following rising edge.
- R9: Changes of `start_n` between clock 1 and the rising edge of clock 12 have no effect on the running frame's hold timing, trial codes or serial bits.
- R10: A synchronous reset (`rst` high at a clock edge) returns the block to idle with `sdata_oe`, `sdata`, `hold` and `trial_code` all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Active-low start-convert line |
| cmp_hi | input | 1 | Comparator decision: 1 when input ≥ trial level |
| hold | output | 1 | Track-and-hold control: 1 holds, 0 tracks |
| trial_code | output | WIDTH (8) | Trial code for the DAC ladder |
| sdata | output | 1 | Serial result bit, MSB first |
| sdata_oe | output | 1 | Enable for the tri-state data pin driver |

## Verification
The bench sweeps all 256 input codes in free-run mode. A sequencer that inverts the keep/clear rule or shifts in the wrong order would corrupt the codes at or near 0x00 and 0xFF. The bench checks the half-cycle placement of each bit, in particular that the LSB is gone in the high half of clock 12 and that hold is released at the falling edge of clock 12. A design off by one edge would show a stale LSB or a late sample release. It samples `start_n` at the closing edge in all three modes. This exposes a design that floats the pin in free-run, keeps it driven after a single shot, or ignores mid-frame releases of start incorrectly. It also applies a reset mid-frame, which must leave no residue in `trial_code` or the enable.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // Total clocks in one frame: calibration/track, one sample clock,
  // one decision per bit, and a closing clock.
  function automatic int frame_clocks(input int width, input int cal_clks);
    return cal_clks + width + 2;
  endfunction

  // Clock number whose falling edge asserts hold.
  function automatic int sample_clock(input int cal_clks);
    return cal_clks + 1;
  endfunction

  // Clock number whose falling edge decides bit b.
  function automatic int decide_clock(input int width, input int cal_clks, input int b);
    return cal_clks + 1 + width - b;
  endfunction
endpackage

// File: rtl/sar_frame_timer.sv
module sar_frame_timer #(
  parameter int WIDTH    = 8,
  parameter int CAL_CLKS = 2,
  parameter int PW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_n,
  output logic [PW-1:0] phase
);
  import sar_seq_pkg::*;
  localparam int FRAME = frame_clocks(WIDTH, CAL_CLKS);

  logic at_end;
  logic idle;
  assign at_end = (phase == PW'(FRAME));
  assign idle   = (phase == '0);

  // phase 0 = idle, phase k = during clock k of the frame
  always_ff @(posedge clk) begin
    if (rst)                          phase <= '0;
    else if ((idle || at_end) && !start_n) phase <= PW'(1);
    else if (at_end)                  phase <= '0;
    else if (!idle)                   phase <= phase + PW'(1);
  end
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int WIDTH    = 8,
  parameter int CAL_CLKS = 2,
  parameter int PW       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PW-1:0]    phase,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] trial,
  output logic             hold,
  output logic             bit_q
);
  import sar_seq_pkg::*;
  localparam int SAMPLE = sample_clock(CAL_CLKS);
  localparam int LAST   = decide_clock(WIDTH, CAL_CLKS, 0);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] dec_hit;
  logic [WIDTH-1:0] trial_nx;
  logic             in_hold;

  // One decode per bit position: which clock decides this bit.
  for (genvar b = 0; b < WIDTH; b++) begin : g_hit
    assign dec_hit[b] = (phase == PW'(decide_clock(WIDTH, CAL_CLKS, b)));
  end

  assign in_hold = (phase >= PW'(SAMPLE)) && (phase <= PW'(LAST));

  always_comb begin
    trial_nx = trial;
    if (phase == PW'(SAMPLE)) trial_nx = MSB_ONLY;
    for (int b = 0; b < WIDTH; b++) begin
      if (dec_hit[b]) trial_nx[b] = cmp_hi;
    end
    for (int b = 1; b < WIDTH; b++) begin
      if (dec_hit[b]) trial_nx[b-1] = 1'b1;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      trial <= '0;
      hold  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      trial <= trial_nx;
      hold  <= in_hold;
      bit_q <= (|dec_hit) & cmp_hi;
    end
  end
endmodule

// File: rtl/sar_pin_ctrl.sv
module sar_pin_ctrl #(
  parameter int WIDTH    = 8,
  parameter int CAL_CLKS = 2,
  parameter int PW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] phase,
  input  logic          start_n,
  input  logic          bit_q,
  output logic          sdata,
  output logic          sdata_oe
);
  import sar_seq_pkg::*;
  localparam int FRAME = frame_clocks(WIDTH, CAL_CLKS);

  logic release_q;
  logic at_end;
  assign at_end = (phase == PW'(FRAME));

  // Closing-edge decision: float the pin when start is high.
  always_ff @(negedge clk) begin
    if (rst) release_q <= 1'b0;
    else     release_q <= at_end && start_n;
  end

  assign sdata_oe = (phase != '0) && !(at_end && release_q);
  assign sdata    = sdata_oe && bit_q && !at_end;
endmodule

// File: rtl/sar_serial_sequencer.sv
module sar_serial_sequencer #(
  parameter int WIDTH    = 8,
  parameter int CAL_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  input  logic             cmp_hi,
  output logic             hold,
  output logic [WIDTH-1:0] trial_code,
  output logic             sdata,
  output logic             sdata_oe
);
  import sar_seq_pkg::*;
  localparam int FRAME = frame_clocks(WIDTH, CAL_CLKS);
  localparam int PW    = $clog2(FRAME + 1);

  logic [PW-1:0] phase;
  logic          bit_q;

  sar_frame_timer #(.WIDTH(WIDTH), .CAL_CLKS(CAL_CLKS), .PW(PW)) u_timer (
    .clk(clk), .rst(rst), .start_n(start_n), .phase(phase)
  );

  sar_bit_engine #(.WIDTH(WIDTH), .CAL_CLKS(CAL_CLKS), .PW(PW)) u_engine (
    .clk(clk), .rst(rst), .phase(phase), .cmp_hi(cmp_hi),
    .trial(trial_code), .hold(hold), .bit_q(bit_q)
  );

  sar_pin_ctrl #(.WIDTH(WIDTH), .CAL_CLKS(CAL_CLKS), .PW(PW)) u_pins (
    .clk(clk), .rst(rst), .phase(phase), .start_n(start_n), .bit_q(bit_q),
    .sdata(sdata), .sdata_oe(sdata_oe)
  );
endmodule

// File: rtl/sar_serial_sequencer_chk.sv
module sar_serial_sequencer_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_n,
  input logic             hold,
  input logic [WIDTH-1:0] trial_code,
  input logic             sdata,
  input logic             sdata_oe
);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  // R2
  start_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!sdata_oe && !start_n) |=> (sdata_oe && !sdata && !hold));

  // R3
  idle_track_chk: assert property (@(posedge clk) disable iff (rst)
    !sdata_oe |-> !hold);

  // R4
  msb_trial_chk: assert property (@(negedge clk) disable iff (rst)
    $rose(hold) |-> (trial_code == MSB_ONLY));

  // R7
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (!sdata_oe && start_n) |=> !sdata_oe);

  // R8
  freerun_drive_chk: assert property (@(negedge clk) disable iff (rst)
    (sdata_oe && !start_n) |=> sdata_oe);

  // R3
  hold_in_frame_chk: assert property (@(negedge clk) disable iff (rst)
    $rose(hold) |-> sdata_oe);
endmodule

bind sar_serial_sequencer sar_serial_sequencer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start_n(start_n), .hold(hold),
  .trial_code(trial_code), .sdata(sdata), .sdata_oe(sdata_oe)
);

// File: tb/sar_serial_sequencer_test.sv
module sar_serial_sequencer_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       start_n;
  logic       cmp_hi;
  logic       hold;
  logic [7:0] trial_code;
  logic       sdata;
  logic       sdata_oe;
  int         vin;
  int         n_checks = 0;
  int         n_fails  = 0;
  bit         done     = 1'b0;

  always #2 clk = ~clk;

  // Ideal comparator: input at or above trial level.
  assign cmp_hi = (vin >= int'(trial_code));

  sar_serial_sequencer uut (
    .clk(clk), .rst(rst), .start_n(start_n), .cmp_hi(cmp_hi),
    .hold(hold), .trial_code(trial_code), .sdata(sdata), .sdata_oe(sdata_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  // Precondition: start_n low, next rising edge is clock 1.
  task automatic frame(input int v, input bit sn_mid, input bit sn_end, input bit glitch);
    int exp_sd, exp_tr, idx;
    vin = v;
    for (int c = 1; c <= 12; c++) begin
      @(posedge clk); #1;
      exp_sd = (c >= 5 && c <= 11) ? ((v >> (12 - c)) & 1) : 0;
      chk(sdata_oe == 1'b1, "R1/R2 oe high (high half)", sdata_oe, 1);
      chk(hold == (c >= 4), "R3 hold (high half)", hold, (c >= 4));
      chk(sdata == exp_sd[0], "R5 sdata (high half)", sdata, exp_sd);
      if (c == 2)  start_n = sn_mid;
      if (glitch && c == 6) start_n = 1'b0;
      if (glitch && c == 8) start_n = 1'b1;
      if (c == 12) start_n = sn_end;
      @(negedge clk); #1;
      exp_sd = (c >= 4 && c <= 11) ? ((v >> (11 - c)) & 1) : 0;
      chk(hold == (c >= 3 && c <= 11), "R3 hold (low half)", hold, (c >= 3 && c <= 11));
      chk(sdata == exp_sd[0], "R5 sdata (low half)", sdata, exp_sd);
      if (c < 12) chk(sdata_oe == 1'b1, "R9 oe in frame", sdata_oe, 1);
      else if (sn_end) chk(sdata_oe == 1'b0, "R7 oe released", sdata_oe, 0);
      else chk(sdata_oe == 1'b1, "R8 oe kept", sdata_oe, 1);
      if (c == 3) chk(trial_code == 8'h80, "R4 trial msb", trial_code, 8'h80);
      if (c >= 4 && c <= 11) begin
        idx = 11 - c;
        exp_tr = ((v >> idx) << idx) | ((idx > 0) ? (1 << (idx - 1)) : 0);
        chk(int'(trial_code) == exp_tr, "R4 trial step", trial_code, exp_tr);
      end
      if (c == 12) chk(int'(trial_code) == v, "R6 result", trial_code, v);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      chk(!sdata_oe && !sdata && !hold, "R7 idle", {sdata_oe, sdata, hold}, 0);
      @(negedge clk); #1;
      chk(!sdata_oe, "R7 idle low half", sdata_oe, 0);
    end
  endtask

  initial begin
    rst = 1'b1; start_n = 1'b1; vin = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!sdata_oe && !sdata && !hold && trial_code == 0, "R10 reset state",
        {sdata_oe, sdata, hold, trial_code}, 0);
    rst = 1'b0;
    idle_cycles(5);

    // Free-run sweep over every code; the last frame ends single-shot.
    start_n = 1'b0;
    for (int v = 0; v < 256; v++) frame(v, 1'b0, (v == 255), 1'b0);
    idle_cycles(4);

    // Single-shot.
    start_n = 1'b0;
    frame(8'h3C, 1'b1, 1'b1, 1'b0);
    idle_cycles(3);

    // Synchronized: release mid-frame, lower before close, restart at once.
    start_n = 1'b0;
    frame(8'hC3, 1'b1, 1'b0, 1'b1);
    frame(8'h01, 1'b1, 1'b1, 1'b0);

    // Synchronized with an idle gap.
    idle_cycles(6);
    start_n = 1'b0;
    frame(8'h80, 1'b1, 1'b1, 1'b0);

    // Reset in the middle of a frame (R10).
    start_n = 1'b0;
    vin = 8'hA5;
    repeat (6) @(posedge clk);
    #1;
    rst = 1'b1; start_n = 1'b1;
    @(posedge clk); #1;
    chk(!sdata_oe && !sdata && !hold && trial_code == 0, "R10 mid-frame reset",
        {sdata_oe, sdata, hold, trial_code}, 0);
    rst = 1'b0;
    idle_cycles(2);
    start_n = 1'b0;
    frame(8'h7F, 1'b0, 1'b1, 1'b0);
    idle_cycles(2);

    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule